// File: doc/BRIEF.md
# Frame Capture Control Core

This block is the register and sequencing core that sits behind a camera's serial host link. A host writes a command register to arm a capture, and the core waits for the sensor's frame sync to fall before it opens the buffer's write path for one image. It counts every pixel byte written in that image. When the next frame sync falls, it closes the write path and raises a done flag that stays set until the host clears it. The host polls the done flag, reads the byte length of the frame from three byte-wide registers, drains the buffer, and then clears the done state.

Beside the capture sequence, the core holds a small general-purpose port that drives the sensor's reset, power-down and power-enable lines. It also issues one-cycle pulses that return the buffer's write and read pointers to the start, and it returns a fixed version code. The serial framing and the buffer memory sit outside this block. The read path is combinational from the register address, so a serial front end can shift out the selected byte with no extra latency.

Top module: `frame_capture_ctl`

## Requirements
- R1: After reset, the status, length, GPIO direction and GPIO output registers all read zero, and `buf_wr_en`, `wptr_reset`, `rptr_reset`, `gpio_oe` and `gpio_out` are low.
- R2: Writing address 0x04 with bit 1 set while idle arms a capture. The write window opens on the first clock at which `sensor_vsync` is sampled low after having been high. While the window is open, `buf_wr_en` follows `pix_stb` and every strobe adds one to the length.
- R3: The window closes at the next falling edge of `sensor_vsync`. Status bit 3 (done) is then set and stays set, `buf_wr_en` stays low, and the length does not change until a clear.
- R4: A start write (0x04 bit 1) that arrives while armed, writing or done, without bit 0, has no effect on the state or on the length.
- R5: Writing 0x04 with bit 0 set returns the core to idle, clears done and zeroes the length from any state. If bit 1 is also set in the same write, the core is armed again.
- R6: A write to 0x04 with bit 4 set gives a one-cycle high pulse on `wptr_reset` in the next cycle. Bit 5 does the same on `rptr_reset`. Neither bit starts a capture.
- R7: The status register at 0x41 reads live `sensor_vsync` in bit 0, live `sensor_shutter` in bit 1 and done in bit 3, with all other bits zero.
- R8: The frame length reads as bits 7:0 at 0x42, bits 15:8 at 0x43, and bits 22:16 at 0x44 in bits 6:0, with 0x44 bit 7 always zero.
- R9: The length counter stops at 2^CNT_W-1 and does not wrap to zero.
- R10: Address 0x05 holds the GPIO direction and 0x06 the GPIO output value, 3 bits each (bit 0 sensor reset, bit 1 power-down, bit 2 power enable). They drive `gpio_oe` and `gpio_out`, read back zero-extended, and 0x45 reads the `gpio_in` pins.
- R11: Address 0x40 reads the VERSION parameter (0x5A by default). Address 0x04 and every unassigned address read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register address for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Readback of the addressed register |
| sensor_vsync | input | 1 | Sensor frame sync |
| sensor_shutter | input | 1 | Shutter state from the sensor |
| pix_stb | input | 1 | Pixel byte available strobe |
| buf_wr_en | output | 1 | Buffer write enable for the current byte |
| wptr_reset | output | 1 | One-cycle buffer write pointer reset |
| rptr_reset | output | 1 | One-cycle buffer read pointer reset |
| gpio_in | input | GPIO_W | Sensor control pin levels |
| gpio_oe | output | GPIO_W | Sensor control pin output enables |
| gpio_out | output | GPIO_W | Sensor control pin output values |

## Verification
The hardest condition to reach from the ports is counter saturation, because the default width needs over eight million strobes. The bench therefore runs a second copy of the core with a 9-bit counter on the same stimulus. One long frame of 70000 strobes fills all three bytes of the full-width length and holds the narrow copy at its ceiling. A start issued in the middle of an open window is also hard to reach. The stimulus places that write between two strobe bursts inside one frame, so any reset of the count would show up in the final length.

// File: rtl/fgc_pkg.sv
package fgc_pkg;

  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    CAP_IDLE    = 2'd0,
    CAP_ARMED   = 2'd1,
    CAP_WRITING = 2'd2,
    CAP_DONE    = 2'd3
  } cap_state_e;

  // register addresses (host software depends on these)
  localparam logic [ADDR_W-1:0] A_CTRL = 7'h04;
  localparam logic [ADDR_W-1:0] A_GDIR = 7'h05;
  localparam logic [ADDR_W-1:0] A_GOUT = 7'h06;
  localparam logic [ADDR_W-1:0] A_VER  = 7'h40;
  localparam logic [ADDR_W-1:0] A_STAT = 7'h41;
  localparam logic [ADDR_W-1:0] A_LEN0 = 7'h42;
  localparam logic [ADDR_W-1:0] A_LEN1 = 7'h43;
  localparam logic [ADDR_W-1:0] A_LEN2 = 7'h44;
  localparam logic [ADDR_W-1:0] A_GIN  = 7'h45;

  // command bits in the control register
  localparam int CB_CLEAR = 0;
  localparam int CB_START = 1;
  localparam int CB_WRST  = 4;
  localparam int CB_RRST  = 5;

  // status bits
  localparam int SB_VSYNC = 0;
  localparam int SB_SHUT  = 1;
  localparam int SB_DONE  = 3;

endpackage

// File: rtl/fgc_ctrl_regs.sv
module fgc_ctrl_regs
  import fgc_pkg::*;
#(
  parameter int GPIO_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              start_cmd,
  output logic              clear_cmd,
  output logic              wptr_rst,
  output logic              rptr_rst,
  output logic [GPIO_W-1:0] gpio_dir,
  output logic [GPIO_W-1:0] gpio_val
);

  logic              ctrl_hit;
  logic              dir_en;
  logic              val_en;
  logic              wptr_d;
  logic              rptr_d;
  logic              wptr_q;
  logic              rptr_q;
  logic [GPIO_W-1:0] dir_q;
  logic [GPIO_W-1:0] val_q;
  logic              unused_wdata;

  assign unused_wdata = ^wdata;

  always_comb begin
    ctrl_hit  = wr_en && (addr == A_CTRL);
    dir_en    = wr_en && (addr == A_GDIR);
    val_en    = wr_en && (addr == A_GOUT);
    start_cmd = ctrl_hit && wdata[CB_START];
    clear_cmd = ctrl_hit && wdata[CB_CLEAR];
    wptr_d    = ctrl_hit && wdata[CB_WRST];
    rptr_d    = ctrl_hit && wdata[CB_RRST];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= 1'b0;
      rptr_q <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
    end else if (dir_en) begin
      dir_q <= wdata[GPIO_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (val_en) begin
      val_q <= wdata[GPIO_W-1:0];
    end
  end

  assign wptr_rst = wptr_q;
  assign rptr_rst = rptr_q;
  assign gpio_dir = dir_q;
  assign gpio_val = val_q;

  AST_WPTR_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    wptr_q |-> $past(wr_en && (addr == A_CTRL) && wdata[CB_WRST])); // R6
  AST_RPTR_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    rptr_q |-> $past(wr_en && (addr == A_CTRL) && wdata[CB_RRST])); // R6

endmodule

// File: rtl/fgc_capture_fsm.sv
module fgc_capture_fsm
  import fgc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic vsync,
  input  logic start_cmd,
  input  logic clear_cmd,
  output logic wr_window,
  output logic done,
  output logic restart
);

  cap_state_e state_q;
  cap_state_e state_d;
  logic       vsync_q;
  logic       vs_fall;
  logic       start_ok;

  always_comb begin
    vs_fall  = vsync_q && !vsync;
    start_ok = start_cmd && ((state_q == CAP_IDLE) || clear_cmd);
    state_d  = state_q;
    if (clear_cmd) begin
      state_d = start_cmd ? CAP_ARMED : CAP_IDLE;
    end else if (start_ok) begin
      state_d = CAP_ARMED;
    end else begin
      case (state_q)
        CAP_ARMED:   if (vs_fall) state_d = CAP_WRITING;
        CAP_WRITING: if (vs_fall) state_d = CAP_DONE;
        default:     state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CAP_IDLE;
      vsync_q <= 1'b0;
    end else begin
      state_q <= state_d;
      vsync_q <= vsync;
    end
  end

  assign wr_window = (state_q == CAP_WRITING);
  assign done      = (state_q == CAP_DONE);
  assign restart   = clear_cmd || start_ok;

  AST_ARM_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CAP_IDLE && start_cmd) |=> (state_q == CAP_ARMED)); // R2
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CAP_WRITING && start_cmd && !clear_cmd && !vs_fall)
      |=> (state_q == CAP_WRITING)); // R4
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CAP_DONE && !clear_cmd) |=> (state_q == CAP_DONE)); // R3
  AST_CLEAR_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_cmd && !start_cmd) |=> (state_q == CAP_IDLE)); // R5

endmodule

// File: rtl/fgc_len_counter.sv
module fgc_len_counter #(
  parameter int CNT_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zero,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = zero || inc;
    if (zero) begin
      cnt_d = '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !zero) |=> (cnt_q == CNT_MAX)); // R9
  AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!zero && !inc) |=> $stable(cnt_q)); // R3

endmodule

// File: rtl/frame_capture_ctl.sv
module frame_capture_ctl
  import fgc_pkg::*;
#(
  parameter int              CNT_W   = 23,
  parameter int              GPIO_W  = 3,
  parameter logic [7:0]      VERSION = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [6:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              sensor_vsync,
  input  logic              sensor_shutter,
  input  logic              pix_stb,
  output logic              buf_wr_en,
  output logic              wptr_reset,
  output logic              rptr_reset,
  input  logic [GPIO_W-1:0] gpio_in,
  output logic [GPIO_W-1:0] gpio_oe,
  output logic [GPIO_W-1:0] gpio_out
);

  localparam int LEN_W   = 3 * DATA_W;
  localparam int LEN_PAD = LEN_W - CNT_W;
  localparam int GPAD    = DATA_W - GPIO_W;

  logic             rst_m1;
  logic             rst_core_n;
  logic             start_cmd;
  logic             clear_cmd;
  logic             wr_window;
  logic             done;
  logic             restart;
  logic [CNT_W-1:0] count;
  logic [LEN_W-1:0] len_ext;
  logic [GPIO_W-1:0] dir_q;
  logic [GPIO_W-1:0] val_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m1     <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_m1     <= 1'b1;
      rst_core_n <= rst_m1;
    end
  end

  fgc_ctrl_regs #(.GPIO_W(GPIO_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_en     (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .start_cmd (start_cmd),
    .clear_cmd (clear_cmd),
    .wptr_rst  (wptr_reset),
    .rptr_rst  (rptr_reset),
    .gpio_dir  (dir_q),
    .gpio_val  (val_q)
  );

  fgc_capture_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .vsync     (sensor_vsync),
    .start_cmd (start_cmd),
    .clear_cmd (clear_cmd),
    .wr_window (wr_window),
    .done      (done),
    .restart   (restart)
  );

  fgc_len_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_core_n),
    .zero  (restart),
    .inc   (wr_window && pix_stb),
    .count (count)
  );

  assign buf_wr_en = wr_window && pix_stb;
  assign gpio_oe   = dir_q;
  assign gpio_out  = val_q;

  generate
    if (LEN_PAD > 0) begin : g_pad
      assign len_ext = {{LEN_PAD{1'b0}}, count};
    end else begin : g_nopad
      assign len_ext = count[LEN_W-1:0];
    end
  endgenerate

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_VER:  reg_rdata = VERSION;
      A_STAT: begin
        reg_rdata[SB_VSYNC] = sensor_vsync;
        reg_rdata[SB_SHUT]  = sensor_shutter;
        reg_rdata[SB_DONE]  = done;
      end
      A_LEN0: reg_rdata = len_ext[7:0];
      A_LEN1: reg_rdata = len_ext[15:8];
      A_LEN2: reg_rdata = {1'b0, len_ext[22:16]};
      A_GDIR: reg_rdata = {{GPAD{1'b0}}, dir_q};
      A_GOUT: reg_rdata = {{GPAD{1'b0}}, val_q};
      A_GIN:  reg_rdata = {{GPAD{1'b0}}, gpio_in};
      default: reg_rdata = '0;
    endcase
  end

  AST_WR_ONLY_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_core_n)
    (done || !pix_stb) |-> !buf_wr_en); // R3

endmodule

// File: tb/frame_capture_ctl_bench.sv
`timescale 1ns/1ps
module frame_capture_ctl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [6:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       sensor_vsync = 1'b0;
  logic       sensor_shutter = 1'b0;
  logic       pix_stb = 1'b0;
  logic [2:0] gpio_in = '0;
  logic [7:0] reg_rdata;
  logic       buf_wr_en, wptr_reset, rptr_reset;
  logic [2:0] gpio_oe, gpio_out;
  logic [7:0] sat_rdata;
  logic       sat_wr_en, sat_wptr, sat_rptr;
  logic [2:0] sat_oe, sat_out;

  int n_chk = 0;
  int n_bad = 0;
  bit cmp_on = 1'b0;

  always #2.5 clk = ~clk;

  frame_capture_ctl u_frame_capture_ctl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sensor_vsync(sensor_vsync),
    .sensor_shutter(sensor_shutter), .pix_stb(pix_stb), .buf_wr_en(buf_wr_en),
    .wptr_reset(wptr_reset), .rptr_reset(rptr_reset), .gpio_in(gpio_in),
    .gpio_oe(gpio_oe), .gpio_out(gpio_out)
  );

  frame_capture_ctl #(.CNT_W(9)) u_frame_capture_ctl_sat (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(sat_rdata), .sensor_vsync(sensor_vsync),
    .sensor_shutter(sensor_shutter), .pix_stb(pix_stb), .buf_wr_en(sat_wr_en),
    .wptr_reset(sat_wptr), .rptr_reset(sat_rptr), .gpio_in(gpio_in),
    .gpio_oe(sat_oe), .gpio_out(sat_out)
  );

  // behavioural reference: 0 idle, 1 armed, 2 writing, 3 done
  int       m_st;
  int       m_cnt;
  bit       m_vq, m_wp, m_rp;
  bit [2:0] m_dir, m_out;
  bit       m_fall, m_hit, m_clr, m_go;
  localparam int M_MAX = (1 << 23) - 1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_vq = 0; m_wp = 0; m_rp = 0; m_dir = 0; m_out = 0;
    end else begin
      m_fall = m_vq && !sensor_vsync;
      m_hit  = reg_wr && (reg_addr == 7'h04);
      m_clr  = m_hit && reg_wdata[0];
      m_go   = m_hit && reg_wdata[1] && (m_st == 0 || m_clr);
      if (m_clr || m_go) m_cnt = 0;
      else if (m_st == 2 && pix_stb && m_cnt < M_MAX) m_cnt = m_cnt + 1;
      if (m_clr) m_st = reg_wdata[1] ? 1 : 0;
      else if (m_go) m_st = 1;
      else if (m_st == 1 && m_fall) m_st = 2;
      else if (m_st == 2 && m_fall) m_st = 3;
      m_wp = m_hit && reg_wdata[4];
      m_rp = m_hit && reg_wdata[5];
      if (reg_wr && reg_addr == 7'h05) m_dir = reg_wdata[2:0];
      if (reg_wr && reg_addr == 7'h06) m_out = reg_wdata[2:0];
      m_vq = sensor_vsync;
    end
  end

  function automatic logic [7:0] m_rd(input logic [6:0] a);
    case (a)
      7'h40: return 8'h5A;
      7'h41: return {4'b0, (m_st == 3), 1'b0, sensor_shutter, sensor_vsync};
      7'h42: return m_cnt[7:0];
      7'h43: return m_cnt[15:8];
      7'h44: return {1'b0, m_cnt[22:16]};
      7'h05: return {5'b0, m_dir};
      7'h06: return {5'b0, m_out};
      7'h45: return {5'b0, gpio_in};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string req_of(input logic [6:0] a);
    case (a)
      7'h41: return "R7";
      7'h42, 7'h43, 7'h44: return "R8";
      7'h05, 7'h06, 7'h45: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      check("R2", buf_wr_en, (m_st == 2) && pix_stb);
      check("R6", wptr_reset, m_wp);
      check("R6", rptr_reset, m_rp);
      check("R10", {gpio_oe, gpio_out}, {m_dir, m_out});
      check(req_of(reg_addr), reg_rdata, m_rd(reg_addr));
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wreg(input logic [6:0] a, input logic [7:0] d);
    tick(); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick(); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a);
    tick(); reg_addr = a;
    @(negedge clk);
  endtask

  task automatic set_vs(input logic v);
    tick(); sensor_vsync = v;
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      tick(); pix_stb = 1'b1;
    end
    tick(); pix_stb = 1'b0;
  endtask

  task automatic frame_edge();
    set_vs(1'b1); set_vs(1'b0); tick();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) tick();
    cmp_on = 1'b1;

    // R1 reset state
    rd(7'h41); check("R1", reg_rdata, 8'h00);
    rd(7'h42); check("R1", reg_rdata, 8'h00);
    rd(7'h44); check("R1", reg_rdata, 8'h00);
    rd(7'h06); check("R1", {reg_rdata, buf_wr_en, wptr_reset, rptr_reset, gpio_oe}, 0);

    // R11 version and unassigned
    rd(7'h40); check("R11", reg_rdata, 8'h5A);
    rd(7'h04); check("R11", reg_rdata, 8'h00);
    rd(7'h17); check("R11", reg_rdata, 8'h00);

    // R10 GPIO
    wreg(7'h05, 8'hFF); rd(7'h05); check("R10", reg_rdata, 8'h07);
    wreg(7'h06, 8'hFD); rd(7'h06); check("R10", reg_rdata, 8'h05);
    check("R10", {gpio_oe, gpio_out}, {3'b111, 3'b101});
    gpio_in = 3'b110; rd(7'h45); check("R10", reg_rdata, 8'h06);

    // R6 pointer pulses
    wreg(7'h04, 8'h10); @(negedge clk);
    check("R6", {wptr_reset, rptr_reset}, 2'b10);
    @(negedge clk); check("R6", wptr_reset, 1'b0);
    wreg(7'h04, 8'h20); @(negedge clk);
    check("R6", {wptr_reset, rptr_reset}, 2'b01);
    rd(7'h41); check("R6", reg_rdata, 8'h00);

    // R2 / R3 first frame of 10 bytes
    set_vs(1'b1); wreg(7'h04, 8'h02); set_vs(1'b0); tick();
    tick(); pix_stb = 1'b1; @(negedge clk); check("R2", buf_wr_en, 1'b1);
    strobes(9);
    frame_edge();
    rd(7'h41); check("R3", reg_rdata, 8'h08);
    rd(7'h42); check("R2", reg_rdata, 8'd10);
    strobes(4); rd(7'h42); check("R3", reg_rdata, 8'd10);

    // R4 start while done
    wreg(7'h04, 8'h02);
    rd(7'h41); check("R4", reg_rdata, 8'h08);
    rd(7'h42); check("R4", reg_rdata, 8'd10);

    // R5 clear
    wreg(7'h04, 8'h01);
    rd(7'h41); check("R5", reg_rdata, 8'h00);
    rd(7'h42); check("R5", reg_rdata, 8'h00);

    // R4 start while writing
    set_vs(1'b1); wreg(7'h04, 8'h02); set_vs(1'b0); tick();
    strobes(5); wreg(7'h04, 8'h02); strobes(5);
    rd(7'h42); check("R4", reg_rdata, 8'd10);
    frame_edge();
    rd(7'h41); check("R3", reg_rdata, 8'h08);

    // R5 clear with start re-arms; R7 live status
    wreg(7'h04, 8'h03);
    rd(7'h42); check("R5", reg_rdata, 8'h00);
    sensor_shutter = 1'b1; set_vs(1'b1);
    rd(7'h41); check("R7", reg_rdata, 8'h03);
    sensor_shutter = 1'b0; set_vs(1'b0); tick();

    // R8 / R9 long frame
    strobes(70000);
    frame_edge();
    rd(7'h41); check("R3", reg_rdata, 8'h08);
    rd(7'h42); check("R8", reg_rdata, 8'h70); check("R9", sat_rdata, 8'hFF);
    rd(7'h43); check("R8", reg_rdata, 8'h11); check("R9", sat_rdata, 8'h01);
    rd(7'h44); check("R8", reg_rdata, 8'h01); check("R9", sat_rdata, 8'h00);

    cmp_on = 1'b0;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule